// File: doc/BRIEF.md
# SAR Converter Digital Interface Controller

This block is the digital control side of a four-channel successive-approximation converter. A falling edge on the active-low conversion-start input, seen while the block is idle, opens a conversion of fixed length. A sample strobe and the selected channel number go out to the analog core; in this project that core is a behavioural stub in the bench. BUSY stays high for the whole conversion. When the core's result is captured in the output register, together with the channel that produced it, BUSY drops.

A host reaches the block over a shared parallel bus with active-low chip select, read and write strobes. The bus works either in word mode, where the result lines up against the top data line, or in byte mode. In byte mode only the low eight lines carry data and line 8 acts as a high-byte enable. A high-byte read returns the top four result bits, a forced-zero bit and the two-bit channel ID. The control register holds the channel select and the output coding (straight binary or twos complement). A write that arrives during a conversion is parked and takes effect when BUSY falls. The resolution parameter selects a 12-bit or 10-bit variant; the 10-bit variant pads its two lowest data lines with zeros.

Two finite-state machines carry the behaviour. The conversion sequencer has states CV_IDLE, CV_DELAY and CV_CONV. Its transitions are: CV_IDLE to CV_DELAY on an accepted start edge, CV_DELAY to CV_CONV after START_DLY cycles, and CV_CONV to CV_IDLE after CONV_CYC cycles with the result captured. The write engine has states WS_OPEN and WS_HELD. It goes from WS_OPEN to WS_HELD when a write is accepted during a conversion that is not in its last cycle, and from WS_HELD back to WS_OPEN on the final conversion cycle, when the parked or concurrent write is applied.

Top module: `sar_if_ctrl`

## Requirements
- R1: A falling edge of convst_n (high at one clock edge, low at the next) while busy is low makes busy rise at that edge. The block then emits a one-cycle samp_pulse, with samp_ch equal to the control register's channel field at that edge.
- R2: busy stays high for exactly START_DLY + CONV_CYC clock cycles (15 with the defaults). The output register captures sar_result at the edge where busy falls and holds it at all other times.
- R3: Falling edges of convst_n while busy is high are ignored: there is no extra samp_pulse, no change in busy length and no change to the captured result.
- R4: db_oe is all zeros unless cs_n and rd_n are both low. During a read, db_oe is 12'hFFF in word mode (wb_sel=1) and 12'h0FF in byte mode (wb_sel=0), with db_out[11:8] zero in byte mode.
- R5: In a word-mode read, db_out is the coded result left-aligned so that its MSB is on line 11.
- R6: In a byte-mode read with db_in[8] low, db_out[7:0] is the low byte of the left-aligned word. With db_in[8] high, db_out[7:0] = {0, id[1:0], 0, word[11:8]}, with the channel ID on lines 6:5.
- R7: In the 10-bit variant (RES=10), lines 1:0 of the left-aligned word read as 0 and the result LSB is on line 2.
- R8: A write is accepted on the first clock edge at which cs_n and wr_n are both low after wr_n was high. The channel field comes from db_in[1:0] and the coding bit from db_in[3], in word mode or in byte mode with db_in[8] low. A byte-mode write with db_in[8] high has no effect.
- R9: With coding 1, the read-out result has its MSB inverted (twos complement); with coding 0 it is straight binary. The coding in force at read time applies.
- R10: A write accepted while busy is high, before the final conversion cycle, does not change the control register until the edge where busy falls. When several writes are parked, the latest one wins.
- R11: The channel ID read back is the channel captured at the start edge of that conversion, whatever later writes change.
- R12: After reset, busy is low, the result, ID, channel and coding are all zero, and the bus is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master conversion clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| convst_n | input | 1 | Conversion start, falling edge starts |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| wb_sel | input | 1 | 1 = word mode, 0 = byte mode |
| db_in | input | 12 | Bus data from the host; line 8 is the high-byte enable in byte mode |
| db_out | output | 12 | Bus data to the host |
| db_oe | output | 12 | Per-line bus drive enable |
| busy | output | 1 | High during a conversion |
| samp_pulse | output | 1 | One-cycle sample strobe to the analog core |
| samp_ch | output | 2 | Channel to sample |
| sar_result | input | RES | Conversion result from the analog core |

## Verification
The bench sweeps every channel and both codings over edge values (zero, full scale, and the values on either side of the MSB flip), reading word, low byte and high byte for the 12-bit and 10-bit variants side by side. A wrong pad or misplaced ID would show as shifted data or a wrong high byte, and a coding done as a two's negation instead of an MSB flip would fail at full scale. Start edges are toggled in the middle of a conversion: a design that restarts would stretch BUSY or recapture a changed stub value. A write during BUSY is read back before and after BUSY falls, so applying it early would change the coding of a read made during the conversion. The bench also checks that a high-byte write does nothing, that a later write leaves the read-back channel ID alone, and that the bus is released whenever chip select or read is inactive.

// File: rtl/sar_if_pkg.sv
package sar_if_pkg;

    localparam int CH_W     = 2;
    localparam int DB_W     = 12;
    localparam int BYTE_W   = 8;
    localparam int HBEN_BIT = 8;
    localparam int F_CHAN   = 0;
    localparam int F_CODING = 3;

    typedef enum logic [1:0] {
        CV_IDLE,
        CV_DELAY,
        CV_CONV
    } cv_state_t;

    typedef enum logic {
        WS_OPEN,
        WS_HELD
    } wr_state_t;

    typedef struct packed {
        logic            coding;
        logic [CH_W-1:0] chan;
    } ctrl_t;

endpackage

// File: rtl/sar_conv_fsm.sv
module sar_conv_fsm
    import sar_if_pkg::*;
#(
    parameter int RES       = 12,
    parameter int START_DLY = 2,
    parameter int CONV_CYC  = 13
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            convst_n,
    input  logic [CH_W-1:0] cur_chan,
    input  logic [RES-1:0]  sar_result,
    output logic            busy,
    output logic            done,
    output logic            samp_pulse,
    output logic [CH_W-1:0] samp_ch,
    output logic [RES-1:0]  res_q,
    output logic [CH_W-1:0] id_q
);

    localparam int MAXC  = (START_DLY > CONV_CYC) ? START_DLY : CONV_CYC;
    localparam int CNT_W = $clog2(MAXC + 1);

    cv_state_t        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             conv_q;
    logic             start_ok;
    logic [CH_W-1:0]  ch_lat;

    assign start_ok = (state_q == CV_IDLE) && conv_q && !convst_n;
    assign done     = (state_q == CV_CONV) && (cnt_q == CNT_W'(CONV_CYC - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CV_IDLE;
            cnt_q   <= '0;
            conv_q  <= 1'b1;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            conv_q  <= convst_n;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            CV_IDLE: begin
                if (start_ok) begin
                    state_d = CV_DELAY;
                    cnt_d   = '0;
                end
            end
            CV_DELAY: begin
                if (cnt_q == CNT_W'(START_DLY - 1)) begin
                    state_d = CV_CONV;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            CV_CONV: begin
                if (done) begin
                    state_d = CV_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                state_d = CV_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            samp_pulse <= 1'b0;
            samp_ch    <= '0;
            ch_lat     <= '0;
            res_q      <= '0;
            id_q       <= '0;
        end else begin
            busy       <= (state_d != CV_IDLE);
            samp_pulse <= start_ok;
            if (start_ok) begin
                samp_ch <= cur_chan;
                ch_lat  <= cur_chan;
            end
            if (done) begin
                res_q <= sar_result;
                id_q  <= ch_lat;
            end
        end
    end

endmodule

// File: rtl/sar_ctrl_reg.sv
module sar_ctrl_reg
    import sar_if_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cs_n,
    input  logic            wr_n,
    input  logic            wb_sel,
    input  logic [DB_W-1:0] db_in,
    input  logic            busy,
    input  logic            done,
    output ctrl_t           ctrl_q,
    output logic            held
);

    wr_state_t wst_q, wst_d;
    logic      wr_q;
    logic      accept;
    logic      defer;
    ctrl_t     wdata;
    ctrl_t     pend_q;
    logic      unused_db;

    assign unused_db    = ^{db_in[DB_W-1:HBEN_BIT+1], db_in[HBEN_BIT-1:F_CODING+1], db_in[2]};
    assign wdata.chan   = db_in[F_CHAN +: CH_W];
    assign wdata.coding = db_in[F_CODING];
    assign accept       = !cs_n && !wr_n && wr_q && (wb_sel || !db_in[HBEN_BIT]);
    assign defer        = accept && busy && !done;
    assign held         = (wst_q == WS_HELD);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wst_q <= WS_OPEN;
            wr_q  <= 1'b1;
        end else begin
            wst_q <= wst_d;
            wr_q  <= wr_n;
        end
    end

    // next state
    always_comb begin
        wst_d = wst_q;
        unique case (wst_q)
            WS_OPEN: if (defer) wst_d = WS_HELD;
            WS_HELD: if (done)  wst_d = WS_OPEN;
            default: wst_d = WS_OPEN;
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            pend_q <= '0;
        end else begin
            unique case (wst_q)
                WS_OPEN: begin
                    if (defer)       pend_q <= wdata;
                    else if (accept) ctrl_q <= wdata;
                end
                WS_HELD: begin
                    if (done)        ctrl_q <= accept ? wdata : pend_q;
                    else if (accept) pend_q <= wdata;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/sar_rd_fmt.sv
module sar_rd_fmt
    import sar_if_pkg::*;
#(
    parameter int RES = 12
) (
    input  logic [RES-1:0]  res_q,
    input  logic [CH_W-1:0] id_q,
    input  logic            coding,
    input  logic            wb_sel,
    input  logic            hben,
    input  logic            cs_n,
    input  logic            rd_n,
    output logic [DB_W-1:0] db_out,
    output logic [DB_W-1:0] db_oe
);

    localparam int PAD = DB_W - RES;

    logic [RES-1:0]    coded;
    logic [DB_W-1:0]   word;
    logic [BYTE_W-1:0] hi_byte;
    logic              rd_en;

    assign coded = res_q ^ {coding, {(RES-1){1'b0}}};

    generate
        if (PAD > 0) begin : g_pad
            assign word = {coded, {PAD{1'b0}}};
        end else begin : g_full
            assign word = coded;
        end
    endgenerate

    assign hi_byte = {1'b0, id_q, 1'b0, word[DB_W-1:BYTE_W]};
    assign rd_en   = !cs_n && !rd_n;

    always_comb begin
        db_out = '0;
        db_oe  = '0;
        if (rd_en) begin
            if (wb_sel) begin
                db_out = word;
                db_oe  = '1;
            end else begin
                db_out = {{(DB_W-BYTE_W){1'b0}}, hben ? hi_byte : word[BYTE_W-1:0]};
                db_oe  = {{(DB_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};
            end
        end
    end

endmodule

// File: rtl/sar_if_ctrl.sv
module sar_if_ctrl
    import sar_if_pkg::*;
#(
    parameter int RES       = 12,
    parameter int START_DLY = 2,
    parameter int CONV_CYC  = 13
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            convst_n,
    input  logic            cs_n,
    input  logic            rd_n,
    input  logic            wr_n,
    input  logic            wb_sel,
    input  logic [11:0]     db_in,
    output logic [11:0]     db_out,
    output logic [11:0]     db_oe,
    output logic            busy,
    output logic            samp_pulse,
    output logic [1:0]      samp_ch,
    input  logic [RES-1:0]  sar_result
);

    ctrl_t           ctrl;
    logic            done;
    logic            wr_held;
    logic [RES-1:0]  res_q;
    logic [CH_W-1:0] id_q;

    sar_conv_fsm #(
        .RES       (RES),
        .START_DLY (START_DLY),
        .CONV_CYC  (CONV_CYC)
    ) u_conv (
        .clk        (clk),
        .rst_n      (rst_n),
        .convst_n   (convst_n),
        .cur_chan   (ctrl.chan),
        .sar_result (sar_result),
        .busy       (busy),
        .done       (done),
        .samp_pulse (samp_pulse),
        .samp_ch    (samp_ch),
        .res_q      (res_q),
        .id_q       (id_q)
    );

    sar_ctrl_reg u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_n   (cs_n),
        .wr_n   (wr_n),
        .wb_sel (wb_sel),
        .db_in  (db_in),
        .busy   (busy),
        .done   (done),
        .ctrl_q (ctrl),
        .held   (wr_held)
    );

    sar_rd_fmt #(
        .RES (RES)
    ) u_rd (
        .res_q  (res_q),
        .id_q   (id_q),
        .coding (ctrl.coding),
        .wb_sel (wb_sel),
        .hben   (db_in[HBEN_BIT]),
        .cs_n   (cs_n),
        .rd_n   (rd_n),
        .db_out (db_out),
        .db_oe  (db_oe)
    );

endmodule

// File: rtl/sar_if_ctrl_chk.sv
module sar_if_ctrl_chk #(
    parameter int RES   = 12,
    parameter int TOTAL = 15
) (
    input logic           clk,
    input logic           rst_n,
    input logic           convst_n,
    input logic           cs_n,
    input logic           rd_n,
    input logic           busy,
    input logic           samp_pulse,
    input logic [11:0]    db_oe,
    input logic [RES-1:0] res_q,
    input logic           wr_held
);

    logic [15:0] hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    hi_cnt <= '0;
        else if (busy) hi_cnt <= hi_cnt + 1'b1;
        else           hi_cnt <= '0;
    end

    // R1
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $fell(convst_n)) |=> busy);

    // R3
    samp_only_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        samp_pulse |-> $rose(busy));

    // R2
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (hi_cnt == 16'(TOTAL)));

    // R2
    res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(res_q));

    // R4
    bus_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || rd_n) |-> (db_oe == 12'h000));

    // R10
    held_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !wr_held);

endmodule

bind sar_if_ctrl sar_if_ctrl_chk #(
    .RES   (RES),
    .TOTAL (START_DLY + CONV_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .convst_n   (convst_n),
    .cs_n       (cs_n),
    .rd_n       (rd_n),
    .busy       (busy),
    .samp_pulse (samp_pulse),
    .db_oe      (db_oe),
    .res_q      (res_q),
    .wr_held    (wr_held)
);

// File: tb/sar_if_ctrl_tb.sv
`timescale 1ns/1ps
module sar_if_ctrl_tb;

    localparam int TOT = 15;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        convst_n = 1'b1;
    logic        cs_n = 1'b1;
    logic        rd_n = 1'b1;
    logic        wr_n = 1'b1;
    logic        wb_sel = 1'b1;
    logic [11:0] db_in = '0;
    logic [11:0] out12, oe12, out10, oe10;
    logic        busy12, busy10, sp12, sp10;
    logic [1:0]  sch12, sch10;
    logic [11:0] stub12 = '0, nv12 = '0;
    logic [9:0]  stub10 = '0, nv10 = '0;
    logic [1:0]  last_ch = '0;
    int          pulses = 0;
    int          total = 0;
    int          bad = 0;
    bit          fin = 0;

    always #4 clk = ~clk;

    sar_if_ctrl #(.RES(12)) u_dut (
        .clk(clk), .rst_n(rst_n), .convst_n(convst_n), .cs_n(cs_n), .rd_n(rd_n),
        .wr_n(wr_n), .wb_sel(wb_sel), .db_in(db_in), .db_out(out12), .db_oe(oe12),
        .busy(busy12), .samp_pulse(sp12), .samp_ch(sch12), .sar_result(stub12));

    sar_if_ctrl #(.RES(10)) u_dut10 (
        .clk(clk), .rst_n(rst_n), .convst_n(convst_n), .cs_n(cs_n), .rd_n(rd_n),
        .wr_n(wr_n), .wb_sel(wb_sel), .db_in(db_in), .db_out(out10), .db_oe(oe10),
        .busy(busy10), .samp_pulse(sp10), .samp_ch(sch10), .sar_result(stub10));

    // behavioural analog core: value taken at the sample strobe
    always @(posedge clk) begin
        if (sp12) begin
            stub12  <= nv12;
            stub10  <= nv10;
            pulses  <= pulses + 1;
            last_ch <= sch12;
        end
    end

    task automatic chk(input string tag, input logic [11:0] got, input logic [11:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    function automatic logic [11:0] exp_word(input logic [11:0] v, input int res, input logic cd);
        int c;
        c = int'(v);
        if (cd) c = c ^ (1 << (res - 1));
        return 12'(c * (1 << (12 - res)));
    endfunction

    function automatic logic [11:0] exp_hi(input logic [11:0] w, input logic [1:0] id);
        return 12'(int'(id) * 32 + int'(w) / 256);
    endfunction

    task automatic wr(input logic wb, input logic [11:0] d);
        @(posedge clk); #2;
        wb_sel = wb; db_in = d; cs_n = 0; wr_n = 0;
        @(posedge clk); #2;
        wr_n = 1; cs_n = 1; db_in = '0;
    endtask

    task automatic rd(input logic wb, input logic hb);
        @(negedge clk);
        wb_sel = wb; db_in = {3'b000, hb, 8'h00}; cs_n = 0; rd_n = 0;
        #1;
    endtask

    task automatic rd_end();
        rd_n = 1; cs_n = 1; db_in = '0; wb_sel = 1;
    endtask

    task automatic conv(input logic [11:0] v, output int blen);
        int n;
        nv12 = v; nv10 = v[11:2];
        @(posedge clk); #2 convst_n = 0;
        @(posedge clk);
        n = 0;
        @(negedge clk);
        while (busy12 && n < 100) begin
            n++;
            @(negedge clk);
        end
        convst_n = 1;
        blen = n;
    endtask

    task automatic check_all(input string tag, input logic [11:0] v, input logic cd, input logic [1:0] id);
        logic [11:0] w12, w10;
        w12 = exp_word(v, 12, cd);
        w10 = exp_word({2'b00, v[11:2]}, 10, cd);
        rd(1, 0);
        chk({tag, " R5 word12"}, out12, w12);
        chk({tag, " R7 word10"}, out10, w10);
        chk({tag, " R4 oe word"}, oe12, 12'hFFF);
        rd_end();
        rd(0, 0);
        chk({tag, " R6 lo12"}, out12, w12 & 12'h0FF);
        chk({tag, " R7 lo10"}, out10, w10 & 12'h0FF);
        chk({tag, " R4 oe byte"}, oe10, 12'h0FF);
        rd_end();
        rd(0, 1);
        chk({tag, " R6 hi12"}, out12, exp_hi(w12, id));
        chk({tag, " R6 hi10"}, out10, exp_hi(w10, id));
        rd_end();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!fin) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int bl, p0;
        logic [11:0] v;
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        @(negedge clk);
        // R12 reset state
        chk("R12 busy", {11'b0, busy12}, 12'h0);
        chk("R12 oe idle", oe12, 12'h000);
        check_all("R12 reset", 12'h000, 0, 2'd0);

        // R4 bus released when only one strobe active
        @(negedge clk); cs_n = 0; rd_n = 1; #1;
        chk("R4 cs only", oe12, 12'h000);
        cs_n = 1; rd_n = 0; #1;
        chk("R4 rd only", oe12, 12'h000);
        rd_n = 1;

        // sweep: channels x coding x values; R1 R2 R5 R6 R7 R8 R9 R11
        for (int ch = 0; ch < 4; ch++) begin
            for (int cd = 0; cd < 2; cd++) begin
                for (int i = 0; i < 6; i++) begin
                    case (i)
                        0: v = 12'h000;
                        1: v = 12'hFFF;
                        2: v = 12'h800;
                        3: v = 12'h7FF;
                        default: v = 12'((i * 1051 + ch * 273 + cd * 97) % 4096);
                    endcase
                    wr(1, 12'(cd * 8 + ch));
                    p0 = pulses;
                    conv(v, bl);
                    chk("R2 busy length", 12'(bl), 12'(TOT));
                    chk("R1 one sample", 12'(pulses - p0), 12'd1);
                    chk("R1 sample chan", {10'b0, last_ch}, 12'(ch));
                    check_all("R9 sweep", v, cd[0], 2'(ch));
                end
            end
        end

        // R3: start edges during busy ignored
        wr(1, 12'h001);
        p0 = pulses;
        nv12 = 12'h3C5; nv10 = 10'h0F1;
        @(posedge clk); #2 convst_n = 0;
        @(posedge clk);
        bl = 0;
        @(negedge clk);
        while (busy12 && bl < 100) begin
            bl++;
            if (bl == 4) begin convst_n = 1; nv12 = 12'hABC; nv10 = 10'h2AF; end
            if (bl == 6) convst_n = 0;
            if (bl == 9) convst_n = 1;
            if (bl == 11) convst_n = 0;
            @(negedge clk);
        end
        convst_n = 1;
        chk("R3 busy length", 12'(bl), 12'(TOT));
        chk("R3 single sample", 12'(pulses - p0), 12'd1);
        rd(1, 0);
        chk("R3 result kept", out12, 12'h3C5);
        chk("R3 result kept 10", out10, 12'h3C4);
        rd_end();

        // R10: write during busy held until busy falls; R11 id kept
        wr(1, 12'h001);
        nv12 = 12'h123; nv10 = 10'h048;
        @(posedge clk); #2 convst_n = 0;
        repeat (4) @(posedge clk);
        #2 convst_n = 1;
        wr(1, 12'h009);   // coding 1, chan 1
        wr(1, 12'h00A);   // latest wins: coding 1, chan 2
        rd(1, 0);
        chk("R10 busy still", {11'b0, busy12}, 12'h1);
        chk("R10 old coding", out12, 12'h3C5);
        rd_end();
        bl = 0;
        @(negedge clk);
        while (busy12 && bl < 100) begin bl++; @(negedge clk); end
        check_all("R10 applied", 12'h123, 1, 2'd1);
        conv(12'h456, bl);
        chk("R10 new chan", {10'b0, last_ch}, 12'h002);
        check_all("R11 new id", 12'h456, 1, 2'd2);
        // R11: change chan after conversion, id stays
        wr(1, 12'h003);
        rd(0, 1);
        chk("R11 id kept", out12, exp_hi(12'h456, 2'd2));
        rd_end();

        // R8: byte high write ignored, byte low write accepted
        wr(1, 12'h001);
        wr(0, 12'h10B);
        conv(12'h9A0, bl);
        chk("R8 hb write no chan", {10'b0, last_ch}, 12'h001);
        check_all("R8 hb write no coding", 12'h9A0, 0, 2'd1);
        wr(0, 12'h00A);
        conv(12'h0F7, bl);
        chk("R8 lo byte chan", {10'b0, last_ch}, 12'h002);
        check_all("R8 lo byte coding", 12'h0F7, 1, 2'd2);

        fin = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule